// File: doc/BRIEF.md
# Interrupt Controller Local Timer

This block is the programmable countdown timer of a per-processor interrupt controller. Software programs three registers through a write/read strobe port. The timer entry holds an interrupt vector, a mask flag and a one-shot/periodic select. The divide register selects a power-of-two prescaler for the base clock. Writing the initial count starts a new count.

Time is measured in prescaled ticks counted from the moment the initial count was written. An expiry occurs every time the elapsed tick count reaches a whole multiple of initial_count + 1. At each expiry the block emits a one-cycle interrupt request that carries the programmed vector. In one-shot mode only the first expiry fires. In periodic mode the expiries stay locked to the original load instant and do not drift. The current count and an expiry-pending flag can be read at any time.

Register addresses on the two-bit `addr` port: 0 timer entry, 1 divide, 2 initial count, 3 current count (read only).

Top module: `irq_local_timer`

## Requirements
- R1: After reset the following hold: the entry is masked with vector 0 in one-shot mode; the divide register reads 0xB (divide-by-1); the initial count and the current count read 0; `expiry_pending` is low; and no pulse is raised.
- R2: The divide register keeps bits 3, 1 and 0 and reads every other bit as zero. The value v = {bit3, bit1, bit0} selects a shift of (v+1) mod 8, so one prescaled tick lasts 2^shift clock cycles. The code 3'b111 gives divide-by-1 and 3'b000 gives divide-by-2.
- R3: Writing the initial count N resets the elapsed tick count to zero, and the current count reads N in the following cycle. No expiry is produced in the cycle of that write.
- R4: In one-shot mode, with N loaded and e prescaled ticks elapsed, the current count is N−e while e ≤ N and 0 afterwards. A single expiry happens when e reaches N+1. `expiry_pending` is high only while the entry is unmasked and e ≤ N.
- R5: In periodic mode with N > 0, an expiry happens every time e becomes a multiple of N+1, measured from the load instant. The current count is N − (e mod (N+1)), and `expiry_pending` is high while the entry is unmasked.
- R6: In periodic mode with an initial count of zero, no pulse is raised, and both the current count and `expiry_pending` read 0.
- R7: While the entry mask is set, no pulse is raised. Counting continues unchanged, and `expiry_pending` is low.
- R8: Each unmasked expiry drives `irq_pulse` high for exactly one cycle. In the cycle after the clock edge on which the expiry occurs, `irq_vector` holds the entry vector that was in force at that edge.
- R9: Writing the divide register leaves the current count unchanged. The next tick then arrives 2^shift cycles after the write, using the new shift.
- R10: In the timer entry, the vector sits in bits 7:0, the mask in bit 16 and the periodic select in bit 17. All other bits are ignored and read as zero. Writes to address 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the register selected by `addr` |
| addr | input | 2 | Register select for both reads and writes |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data of the selected register |
| irq_pulse | output | 1 | One-cycle interrupt request on expiry |
| irq_vector | output | 8 | Vector that goes with `irq_pulse` |
| expiry_pending | output | 1 | An expiry is still scheduled |

## Verification
The bench models time as a load instant plus a shift, with a rebase point at each divide write. From that model it predicts the pulse, the vector, the current count and the pending flag in every cycle. Random sequences mix loads of small counts, including zero, with divide codes covering all eight shifts, entry writes that flip the mode and the mask, and idle stretches.

Small counts with long idle runs show whether the one-shot and periodic schedules differ as they should, and whether periodic expiries stay aligned to the load instant. Divide writes that land in the middle of a period show whether the count holds steady at the write and then ticks at the new rate. Mask toggles and periodic loads of zero separate "counting but silent" from "counting and firing". Directed register writes with junk in the unused bits confirm the field positions.

// File: rtl/irq_local_timer.sv
module irq_local_timer #(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [31:0]      wr_data,
  output logic [31:0]      rd_data,
  output logic             irq_pulse,
  output logic [VEC_W-1:0] irq_vector,
  output logic             expiry_pending
);
  localparam logic [1:0] A_ENTRY = 2'd0;
  localparam logic [1:0] A_DIV   = 2'd1;
  localparam logic [1:0] A_INIT  = 2'd2;
  localparam logic [1:0] A_CUR   = 2'd3;
  localparam int MASK_BIT = 16;
  localparam int PER_BIT  = 17;

  logic [VEC_W-1:0] vec;
  logic             masked, periodic, done;
  logic [2:0]       div_code;
  logic [CNT_W-1:0] init_cnt, phase, cur_cnt;
  logic [7:0]       pre, pre_lim;
  logic [2:0]       shift;
  logic             tick, wrap, evt, ld_wr, div_wr, ent_wr;

  assign ent_wr  = wr_en && addr == A_ENTRY;
  assign div_wr  = wr_en && addr == A_DIV;
  assign ld_wr   = wr_en && addr == A_INIT;
  assign shift   = div_code + 3'd1;
  assign pre_lim = (8'd1 << shift) - 8'd1;
  assign tick    = pre == pre_lim;
  assign wrap    = phase == init_cnt;
  assign evt     = tick && wrap && !ld_wr && !div_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec       <= '0;
      masked    <= 1'b1;
      periodic  <= 1'b0;
      div_code  <= 3'b111;
      init_cnt  <= '0;
      phase     <= '0;
      pre       <= '0;
      done      <= 1'b1;
      irq_pulse <= 1'b0;
      irq_vector <= '0;
    end else begin
      irq_pulse  <= evt && !masked && (periodic ? (init_cnt != '0) : !done);
      irq_vector <= vec;
      if (ent_wr) begin
        vec      <= wr_data[VEC_W-1:0];
        masked   <= wr_data[MASK_BIT];
        periodic <= wr_data[PER_BIT];
      end
      if (div_wr) begin
        div_code <= {wr_data[3], wr_data[1], wr_data[0]};
        pre      <= '0;
      end else if (ld_wr) begin
        init_cnt <= wr_data[CNT_W-1:0];
        phase    <= '0;
        pre      <= '0;
        done     <= 1'b0;
      end else begin
        pre <= tick ? 8'd0 : pre + 8'd1;
        if (tick) phase <= wrap ? '0 : phase + 1'b1;
        if (evt) done <= 1'b1;
      end
    end
  end

  assign cur_cnt        = (!periodic && done) ? '0 : init_cnt - phase;
  assign expiry_pending = !masked && (periodic ? (init_cnt != '0) : !done);

  always_comb begin
    rd_data = '0;
    case (addr)
      A_ENTRY: begin
        rd_data[VEC_W-1:0] = vec;
        rd_data[MASK_BIT]  = masked;
        rd_data[PER_BIT]   = periodic;
      end
      A_DIV:   rd_data[3:0] = {div_code[2], 1'b0, div_code[1:0]};
      A_INIT:  rd_data[CNT_W-1:0] = init_cnt;
      A_CUR:   rd_data[CNT_W-1:0] = cur_cnt;
      default: rd_data = '0;
    endcase
  end
endmodule

module irq_local_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       addr,
  input logic [31:0]      wr_data,
  input logic             irq_pulse,
  input logic             masked,
  input logic             periodic,
  input logic [CNT_W-1:0] init_cnt,
  input logic [CNT_W-1:0] cur_cnt
);
  a_r7_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
    masked |=> !irq_pulse);
  a_r8_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);
  a_r6_zero_periodic: assert property (@(posedge clk) disable iff (!rst_n)
    (periodic && init_cnt == '0 && !wr_en) |=> !irq_pulse);
  a_r3_load_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd2) |=> (cur_cnt == $past(wr_data[CNT_W-1:0])));
  a_r9_div_no_jump: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd1) |=> $stable(cur_cnt));
  a_r4_oneshot_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pulse && !periodic && !wr_en) |-> (cur_cnt == '0));
endmodule

bind irq_local_timer irq_local_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .irq_pulse(irq_pulse), .masked(masked), .periodic(periodic),
  .init_cnt(init_cnt), .cur_cnt(cur_cnt)
);

// File: tb/irq_local_timer_tb.sv
module irq_local_timer_tb;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [1:0] addr = 2'd3;
  logic [31:0] wr_data = '0, rd_data;
  logic irq_pulse, expiry_pending;
  logic [7:0] irq_vector;

  irq_local_timer u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .irq_pulse(irq_pulse),
    .irq_vector(irq_vector), .expiry_pending(expiry_pending));

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;
  longint cyc = 0;
  bit m_mask, m_per;
  logic [7:0] m_vec;
  longint m_ic, m_base, m_rb;
  int m_shift;
  logic [3:0] m_div;

  function automatic longint elapsed(longint t);
    return m_base + ((t - m_rb) >> m_shift);
  endfunction

  function automatic longint exp_count(longint e);
    if (m_per) return m_ic - (e % (m_ic + 1));
    return (e > m_ic) ? 0 : m_ic - e;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic rd(logic [1:0] a, string req, longint exp);
    addr = a; #1;
    check(rd_data == 32'(exp), req, rd_data, exp);
  endtask

  task automatic step(bit w, logic [1:0] a, logic [31:0] d);
    longint e_prev, e_now, ec;
    bit om, op, supp, ep, xirq;
    logic [7:0] ov;
    string tag;
    wr_en = w; addr = a; wr_data = d;
    e_prev = elapsed(cyc); om = m_mask; op = m_per; ov = m_vec; supp = 0;
    tag = op ? "R5" : "R4";
    @(posedge clk); cyc++;
    if (w) case (a)
      2'd0: begin m_vec = d[7:0]; m_mask = d[16]; m_per = d[17]; end
      2'd1: begin m_base = e_prev; m_rb = cyc; m_div = {d[3], 1'b0, d[1:0]};
              m_shift = (int'({d[3], d[1], d[0]}) + 1) % 8; supp = 1; tag = "R9"; end
      2'd2: begin m_ic = longint'(d); m_base = 0; m_rb = cyc; supp = 1; tag = "R3"; end
      default: tag = "R10";
    endcase
    e_now = elapsed(cyc);
    xirq = !supp && e_now > e_prev && (e_now % (m_ic + 1)) == 0 && !om &&
           (op ? m_ic != 0 : e_now == m_ic + 1);
    @(negedge clk); wr_en = 1'b0;
    if (om) check(irq_pulse == 1'b0, "R7", irq_pulse, 0);
    else if (op && m_ic == 0) check(irq_pulse == 1'b0, "R6", irq_pulse, 0);
    else check(irq_pulse == xirq, tag, irq_pulse, xirq);
    if (xirq) check(irq_vector == ov, "R8", irq_vector, ov);
    ec = exp_count(e_now);
    rd(2'd3, tag, ec);
    ep = !m_mask && (m_per ? m_ic != 0 : e_now <= m_ic);
    check(expiry_pending == ep, m_mask ? "R7" : tag, expiry_pending, ep);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 2'd3, '0);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_mask = 1; m_per = 0; m_vec = 0; m_ic = 0; m_base = 1; m_rb = 0; m_shift = 0;
    m_div = 4'hB;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    rd(2'd0, "R1", 32'h0001_0000);
    rd(2'd1, "R1", 32'hB);
    rd(2'd2, "R1", 0);
    rd(2'd3, "R1", 0);
    check(expiry_pending == 0, "R1", expiry_pending, 0);
    check(irq_pulse == 0, "R1", irq_pulse, 0);

    step(1, 2'd0, 32'hFFFC_0042);
    rd(2'd0, "R10", 32'h0000_0042);
    step(1, 2'd1, 32'hFFFF_FFF0);
    rd(2'd1, "R2", 32'h0);
    step(1, 2'd1, 32'h0000_0007);
    rd(2'd1, "R2", 32'h3);
    step(1, 2'd1, 32'h0000_000B);
    rd(2'd1, "R2", 32'hB);
    step(1, 2'd2, 32'd3);
    idle(8);
    step(1, 2'd3, 32'd99);
    rd(2'd2, "R10", 3);
    step(1, 2'd0, 32'h0002_0055);
    step(1, 2'd2, 32'd2);
    idle(10);
    step(1, 2'd1, 32'h0);
    idle(4);
    step(1, 2'd1, 32'h3);
    idle(30);
    step(1, 2'd0, 32'h0003_0055);
    idle(10);
    step(1, 2'd0, 32'h0002_0011);
    step(1, 2'd2, 32'd0);
    idle(6);

    for (int it = 0; it < 400; it++) begin
      int k;
      k = $urandom_range(0, 9);
      if (k < 2)
        step(1, 2'd0, ($urandom & 32'hFFF0_FFFF) | ($urandom_range(0, 9) < 3 ? 32'h1_0000 : 0));
      else if (k < 4) step(1, 2'd1, $urandom);
      else if (k < 6) step(1, 2'd2, $urandom_range(0, 12));
      else if (k == 6) step(1, 2'd3, $urandom);
      else idle($urandom_range(1, 150));
    end
    finished = 1;
    summary();
  end
endmodule